// File: doc/BRIEF.md
# Bit-Serial Weighted-Sum Adder Tree

This block forms the weighted sum of one row of a Hopfield associative memory. Each neuron input is one bit and each weight is a signed 12-bit word. A neuron state of one adds the weight to the sum, and a state of zero adds the weight's negation. The multiply is therefore a selection between the weight and its two's complement. No multiplier is built.

Each of the N leaves sign-extends its selected value and loads it into a parallel-load shift register. The leaf then shifts the value out least significant bit first. Adjacent streams are added in pairs by one-bit serial adders. Each adder has a carry flip-flop and a registered output bit. The adders form a binary tree of log2(N) levels. A collector at the root shifts the final stream back into a parallel word. The result is presented with a one-cycle valid pulse.

Each extra tree level adds one bit of width and one register stage. Doubling the row width therefore costs two cycles of latency. A surrounding controller supplies the weights and the neuron states. It pulses start and reads the sum back when valid is high.

Top module: `wsum_tree`

## Requirements
- R1: For each leaf j, weight j is taken from `weight_i[j*12 +: 12]` and state j from `state_i[j]`. The result equals the sum over all leaves of (state ? weight : -weight).
- R2: Weights are signed 12-bit two's complement values. The result is 12 + log2(N) + 1 bits wide (16 bits for N = 8). The result is exact for every input, including eight negated weights of -2048, which give +16384.
- R3: Valid goes high exactly 12 + 2*log2(N) + 1 clock edges after the edge that accepts start. With N = 8 this is 19 edges.
- R4: Valid is a pulse that lasts one cycle.
- R5: A start that arrives while a sum is in progress is ignored. It causes no extra result and does not disturb the running sum or its timing.
- R6: After reset the sum output is 0 and valid is low. The sum output holds the last result until the next result completes.
- R7: A start in the cycle where valid is high is accepted. Back-to-back sums are each correct, with no carry left over from the previous word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a sum when the tree is idle |
| weight_i | input | N_IN*W_W | Packed row weights, leaf j at bits j*W_W upward |
| state_i | input | N_IN | Neuron states, one bit per leaf |
| sum_o | output | W_W+log2(N_IN)+1 | Signed weighted sum of the last completed run |
| valid_o | output | 1 | One-cycle pulse when sum_o takes a new result |

## Verification
The tree is driven with uniform rows at both extremes of the weight range, under all-ones and all-zeros states. These rows expose any truncated sign extension or missing guard bit, and the negated minimum weight is the sharpest of them. A ramp of weights with alternating states, and rows with a single nonzero leaf at each position, show that each leaf reaches the right tree input with the right polarity. Pseudo-random rows follow, then a back-to-back pair and a start issued in the middle of a run. These separate a carry that leaks between words from a start that is wrongly accepted while busy.

// File: rtl/wsum_pkg.sv
package wsum_pkg;
    // state held by one bit-serial adder node
    typedef struct packed {
        logic carry;
        logic sbit;
    } sadd_t;
endpackage

// File: rtl/wsum_leaf.sv
module wsum_leaf #(
    parameter int W_W   = 12,
    parameter int SUM_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [W_W-1:0] weight_i,
    input  logic           state_i,
    output logic           ser_o
);
    localparam int EXT = SUM_W - W_W;

    logic [SUM_W-1:0] ext;
    logic [SUM_W-1:0] sel;
    logic [SUM_W-1:0] shreg_d, shreg_q;

    always_comb begin
        ext = {{EXT{weight_i[W_W-1]}}, weight_i};
        // negate after widening so the minimum weight does not wrap
        sel = state_i ? ext : (~ext + 1'b1);
        if (load_i) begin
            shreg_d = sel;
        end else begin
            shreg_d = {shreg_q[SUM_W-1], shreg_q[SUM_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg_q <= '0;
        else        shreg_q <= shreg_d;
    end

    assign ser_o = shreg_q[0];

    // sign bit is replicated while shifting (R2)
    assert_sign_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> shreg_q[SUM_W-1] == $past(shreg_q[SUM_W-1]));
endmodule

// File: rtl/wsum_sadd.sv
module wsum_sadd
    import wsum_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic a_i,
    input  logic b_i,
    output logic s_o
);
    sadd_t st_d, st_q;
    logic  cin;

    always_comb begin
        cin        = clr_i ? 1'b0 : st_q.carry;
        st_d.sbit  = a_i ^ b_i ^ cin;
        st_d.carry = (a_i & b_i) | (a_i & cin) | (b_i & cin);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s_o = st_q.sbit;

    // bit 0 of a word sees no carry-in: output equals a xor b (R7)
    assert_word_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> s_o == ($past(a_i) ^ $past(b_i)));
endmodule

// File: rtl/wsum_ctrl.sv
module wsum_ctrl #(
    parameter int LVL   = 3,
    parameter int SUM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             root_i,
    output logic             load_o,
    output logic [LVL-1:0]   clr_o,
    output logic [SUM_W-1:0] sum_o,
    output logic             valid_o
);
    localparam int CNT_W = $clog2(LVL + SUM_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LVL + SUM_W - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [SUM_W-1:0] acc;
        logic [SUM_W-1:0] sum;
        logic             valid;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        load_o      = start_i && !ctl_q.busy;
        if (load_o) begin
            ctl_d.busy = 1'b1;
            ctl_d.cnt  = '0;
        end else if (ctl_q.busy) begin
            ctl_d.acc = {root_i, ctl_q.acc[SUM_W-1:1]};
            if (ctl_q.cnt == LAST) begin
                ctl_d.busy  = 1'b0;
                ctl_d.valid = 1'b1;
                ctl_d.sum   = {root_i, ctl_q.acc[SUM_W-1:1]};
            end else begin
                ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // level k+1 starts its word k cycles after the leaves
    for (genvar k = 0; k < LVL; k++) begin : g_clr
        assign clr_o[k] = ctl_q.busy && (ctl_q.cnt == CNT_W'(k));
    end

    assign sum_o   = ctl_q.sum;
    assign valid_o = ctl_q.valid;

    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.valid |=> !ctl_q.valid);

    assert_valid_ends_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.valid |-> !ctl_q.busy && $past(ctl_q.busy));

    assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.busy && start_i && ctl_q.cnt != LAST)
            |=> ctl_q.busy && ctl_q.cnt == $past(ctl_q.cnt) + 1'b1);

    assert_sum_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_q.sum) |-> ctl_q.valid);
endmodule

// File: rtl/wsum_tree.sv
module wsum_tree #(
    parameter  int N_IN  = 8,
    parameter  int W_W   = 12,
    localparam int LVL   = $clog2(N_IN),
    localparam int SUM_W = W_W + LVL + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [N_IN*W_W-1:0] weight_i,
    input  logic [N_IN-1:0]     state_i,
    output logic [SUM_W-1:0]    sum_o,
    output logic                valid_o
);
    // heap numbering: node 1 is the root, leaf j is node N_IN+j
    logic [2*N_IN-1:1] node;
    logic              load;
    logic [LVL-1:0]    clr;

    for (genvar j = 0; j < N_IN; j++) begin : g_leaf
        wsum_leaf #(.W_W(W_W), .SUM_W(SUM_W)) u_leaf (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (load),
            .weight_i (weight_i[j*W_W +: W_W]),
            .state_i  (state_i[j]),
            .ser_o    (node[N_IN+j])
        );
    end

    for (genvar i = 1; i < N_IN; i++) begin : g_node
        localparam int DEPTH = $clog2(i + 1) - 1;
        localparam int CIDX  = LVL - DEPTH - 1;
        wsum_sadd u_add (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr[CIDX]),
            .a_i   (node[2*i]),
            .b_i   (node[2*i+1]),
            .s_o   (node[i])
        );
    end

    wsum_ctrl #(.LVL(LVL), .SUM_W(SUM_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .root_i  (node[1]),
        .load_o  (load),
        .clr_o   (clr),
        .sum_o   (sum_o),
        .valid_o (valid_o)
    );
endmodule

// File: tb/sim_wsum_tree.sv
`timescale 1ns/1ps
module sim_wsum_tree;
    localparam int N   = 8;
    localparam int W   = 12;
    localparam int L   = 3;
    localparam int SW  = W + L + 1;
    localparam int LAT = W + 2*L + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [N*W-1:0]    weights = '0;
    logic [N-1:0]      states = '0;
    logic [SW-1:0]     sum;
    logic              valid;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic prev_v = 1'b0;
    logic signed [SW-1:0] last_exp = '0;
    logic signed [SW-1:0] exp_q[$];
    int                   t_q[$];

    wsum_tree #(.N_IN(N), .W_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .weight_i(weights),
        .state_i(states), .sum_o(sum), .valid_o(valid)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic signed [SW-1:0] calc(input logic [N*W-1:0] w,
                                                  input logic [N-1:0] s);
        longint acc = 0;
        for (int j = 0; j < N; j++) begin
            longint v = longint'($signed(w[j*W +: W]));
            acc += s[j] ? v : -v;
        end
        return SW'(acc);
    endfunction

    // driver: call just after a negedge; pushes the expected item
    task automatic run(input logic [N*W-1:0] w, input logic [N-1:0] s);
        weights = w;
        states  = s;
        start   = 1'b1;
        @(posedge clk);
        #1;
        exp_q.push_back(calc(w, s));
        t_q.push_back(cyc);
        last_exp = calc(w, s);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [N*W-1:0] fill(input logic [W-1:0] v);
        logic [N*W-1:0] r;
        for (int j = 0; j < N; j++) r[j*W +: W] = v;
        return r;
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_v)
                check(!valid, "R4", "valid width", longint'(valid), 0);
            if (valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected result", longint'($signed(sum)), 0);
                end else begin
                    logic signed [SW-1:0] e;
                    int t;
                    e = exp_q.pop_front();
                    t = t_q.pop_front();
                    check($signed(sum) == e, "R1", "sum", longint'($signed(sum)), longint'(e));
                    check(cyc - t == LAT, "R3", "latency", cyc - t, LAT);
                end
            end
            prev_v = valid;
        end
    end

    initial begin
        #(200000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [N*W-1:0] w;
        logic [N-1:0]   s;
        repeat (3) @(negedge clk);
        check(sum == '0, "R6", "reset sum", longint'(sum), 0);
        check(valid == 1'b0, "R6", "reset valid", longint'(valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 extremes
        run(fill(12'sd2047), '1);        wait_done();
        run(fill(12'h800), '0);          wait_done();   // +16384
        check($signed(sum) == 16384, "R2", "negated minimum", longint'($signed(sum)), 16384);
        run(fill(12'h800), '1);          wait_done();   // -16384
        check($signed(sum) == -16384, "R2", "minimum", longint'($signed(sum)), -16384);

        // ramp, alternating states (R1)
        for (int j = 0; j < N; j++) w[j*W +: W] = W'(j + 1);
        run(w, 8'b0101_0101);            wait_done();

        // one nonzero leaf at each position (R1)
        for (int p = 0; p < N; p++) begin
            w = '0;
            w[p*W +: W] = W'(-(p * 37 + 5));
            run(w, N'(p * 3 + 1));       wait_done();
        end

        // pseudo-random rows (R1)
        for (int r = 0; r < 6; r++) begin
            for (int j = 0; j < N; j++) w[j*W +: W] = W'($urandom);
            s = N'($urandom);
            run(w, s);                   wait_done();
        end

        // R6 hold after completion
        repeat (10) @(negedge clk);
        check($signed(sum) == last_exp, "R6", "held sum", longint'($signed(sum)), longint'(last_exp));

        // R5 start while busy is ignored
        for (int j = 0; j < N; j++) w[j*W +: W] = W'(100 * j - 300);
        run(w, 8'b1100_1010);
        repeat (4) @(negedge clk);
        weights = fill(12'sd999);
        states  = '1;
        start   = 1'b1;
        repeat (3) @(negedge clk);
        start   = 1'b0;
        wait_done();
        repeat (LAT + 4) @(negedge clk);
        check(exp_q.size() == 0, "R5", "pending items", exp_q.size(), 0);
        check($signed(sum) == last_exp, "R5", "sum after ignored start",
              longint'($signed(sum)), longint'(last_exp));

        // R7 back-to-back
        run(fill(12'sd1500), 8'b1111_0000);
        do @(negedge clk); while (!valid);
        run(fill(12'sd1), '1);
        do @(negedge clk); while (!valid);
        run(fill(12'h7FF), '0);
        wait_done();
        check($signed(sum) == -16376, "R7", "back-to-back last", longint'($signed(sum)), -16376);

        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule